// File: doc/BRIEF.md
# Board Control Port Router with Pulse Timing

This block steers the reset and analyse control of a board of processing modules and merges their error reports. Module 0 takes its control either from a host computer or from an upstream board (upstream lines are active-low). The other modules form one group, the "rest" group. It follows either the same source as module 0 or the subsystem outputs that module 0 drives itself. The rest group's control is also sent on to a downstream board, active-low. A two-bit configuration register makes both choices.

Every reset and analyse output is held for a minimum number of clock cycles, so a short request still gives a pulse wide enough for the modules. After a reset pulse ends, each group's ready flag stays low for a further quiet period, and software must wait for that flag before it boots the modules. Error inputs are active-low and wire-ORed. Errors from the group that module 0's source controls are reported to that source. Errors from the subsystem side go back to module 0 only and never reach the upstream port.

Top module: `subctl_port`

## Requirements
- R1: While reset is high and in the first cycle after it, all reset and analyse outputs are low, both down outputs are high, both ready flags are high, `up_err_n_o` and `mod0_sub_err_n_o` are high and `host_err_o` is low. The configuration resets to 00.
- R2: Configuration bit 0 selects module 0's source: 0 selects the host (`host_*_i`, active-high) and 1 selects the upstream port (`up_*_n_i`, active-low). The source that is not selected has no effect on module 0's outputs.
- R3: Configuration bit 1 selects the rest group's source: 0 selects the same source as module 0 and 1 selects module 0's subsystem outputs (`sub_*_i`). The other choice has no effect on the rest group.
- R4: `down_reset_n_o` and `down_analyse_n_o` carry the rest group's reset and analyse as active-low levels, with the same timing.
- R5: A request lasting one cycle makes its output go high in the next cycle. The output then stays high for exactly MIN_CYC cycles.
- R6: A request held for L cycles, where L is at least MIN_CYC, gives an output that is high for exactly L cycles and falls in the cycle after the request is removed.
- R7: A group's ready flag is low while either of its outputs is high. After a reset pulse ends, the flag stays low for QUIET_CYC more cycles. An analyse pulse adds no quiet period.
- R8: A low on module 0's error input, or on any error input of a group that follows module 0, drives `up_err_n_o` low when the upstream port is the source and `host_err_o` high when the host is the source, one cycle later.
- R9: A low on `sub_err_n_i` drives `mod0_sub_err_n_o` low one cycle later. It never changes `up_err_n_o` or `host_err_o`.
- R10: Errors from the rest modules (`mod_err_n_i[N_MOD-1:1]`) and from `down_err_n_i` are reported along the same path that feeds control to that group. This is the master path when bit 1 is 0 and `mod0_sub_err_n_o` when bit 1 is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 2 | Bit 0: module 0 takes the upstream port; bit 1: rest group follows module 0's subsystem outputs |
| host_reset_i | input | 1 | Host reset request, active-high |
| host_analyse_i | input | 1 | Host analyse request, active-high |
| up_reset_n_i | input | 1 | Upstream reset, active-low |
| up_analyse_n_i | input | 1 | Upstream analyse, active-low |
| sub_reset_i | input | 1 | Module 0 subsystem reset, active-high |
| sub_analyse_i | input | 1 | Module 0 subsystem analyse, active-high |
| mod_err_n_i | input | N_MOD | Module error inputs, active-low, bit 0 is module 0 |
| sub_err_n_i | input | 1 | Subsystem port error, active-low |
| down_err_n_i | input | 1 | Downstream board error, active-low |
| mod0_reset_o | output | 1 | Module 0 reset |
| mod0_analyse_o | output | 1 | Module 0 analyse |
| rest_reset_o | output | 1 | Rest group reset |
| rest_analyse_o | output | 1 | Rest group analyse |
| down_reset_n_o | output | 1 | Downstream reset, active-low |
| down_analyse_n_o | output | 1 | Downstream analyse, active-low |
| mod0_ready_o | output | 1 | Module 0 may be booted |
| rest_ready_o | output | 1 | Rest group may be booted |
| up_err_n_o | output | 1 | Error toward upstream, active-low |
| host_err_o | output | 1 | Error toward host, active-high |
| mod0_sub_err_n_o | output | 1 | Error toward module 0's subsystem, active-low |

## Verification
A hold counter left in the wrong state shows as a pulse that is one cycle too short or too long. It becomes visible at the falling edge of the output, MIN_CYC cycles after the request. A quiet counter in the wrong state moves the rising edge of ready away from QUIET_CYC cycles after reset falls. A wrong configuration bit shows at once: a request goes to the wrong output, or an error goes out on the wrong port, one cycle after the stimulus. So every check aims at an exact edge cycle rather than at a level.

// File: rtl/subctl_pkg.sv
package subctl_pkg;
  typedef enum logic {SRC_HOST = 1'b0, SRC_UP = 1'b1} mod0_src_e;
  typedef enum logic {FOLLOW_MOD0 = 1'b0, FOLLOW_SUB = 1'b1} rest_src_e;
  typedef struct packed {
    rest_src_e rest_src;
    mod0_src_e mod0_src;
  } cfg_t;
endpackage

// File: rtl/subctl_cfg_reg.sv
module subctl_cfg_reg
  import subctl_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       we,
  input  logic [1:0] wdata,
  output cfg_t       cfg_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_o <= '{rest_src: FOLLOW_MOD0, mod0_src: SRC_HOST};
    end else if (we) begin
      cfg_o <= cfg_t'(wdata);
    end
  end
endmodule

// File: rtl/subctl_stretch.sv
module subctl_stretch #(
  parameter int MIN_CYC   = 4,
  parameter int QUIET_CYC = 0
) (
  input  logic clk,
  input  logic rst,
  input  logic req_i,
  output logic act_o,
  output logic busy_o
);
  localparam int LIM   = (MIN_CYC > QUIET_CYC) ? MIN_CYC : QUIET_CYC;
  localparam int CNT_W = $clog2(LIM + 1);

  logic [CNT_W-1:0] hold_q;
  logic             keep;

  assign keep = req_i || (hold_q != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      act_o  <= 1'b0;
      hold_q <= '0;
    end else begin
      act_o <= keep;
      if (!act_o && req_i) begin
        hold_q <= CNT_W'(MIN_CYC - 1);
      end else if (hold_q != '0) begin
        hold_q <= hold_q - 1'b1;
      end
    end
  end

  generate
    if (QUIET_CYC > 0) begin : g_quiet
      logic [CNT_W-1:0] quiet_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          quiet_q <= '0;
        end else if (act_o && !keep) begin
          quiet_q <= CNT_W'(QUIET_CYC);
        end else if (quiet_q != '0) begin
          quiet_q <= quiet_q - 1'b1;
        end
      end
      assign busy_o = act_o || (quiet_q != '0);
    end else begin : g_noquiet
      assign busy_o = act_o;
    end
  endgenerate
endmodule

// File: rtl/subctl_err_route.sv
module subctl_err_route
  import subctl_pkg::*;
#(
  parameter int N_MOD = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  cfg_t             cfg_i,
  input  logic [N_MOD-1:0] mod_err_n_i,
  input  logic             sub_err_n_i,
  input  logic             down_err_n_i,
  output logic             up_err_n_o,
  output logic             host_err_o,
  output logic             sub_err_n_o
);
  logic rest_err, master_err, local_err;

  assign rest_err   = !(&mod_err_n_i[N_MOD-1:1]) || !down_err_n_i;
  assign master_err = !mod_err_n_i[0] ||
                      (rest_err && cfg_i.rest_src == FOLLOW_MOD0);
  assign local_err  = !sub_err_n_i ||
                      (rest_err && cfg_i.rest_src == FOLLOW_SUB);

  always_ff @(posedge clk) begin
    if (rst) begin
      up_err_n_o  <= 1'b1;
      host_err_o  <= 1'b0;
      sub_err_n_o <= 1'b1;
    end else begin
      up_err_n_o  <= !(master_err && cfg_i.mod0_src == SRC_UP);
      host_err_o  <= master_err && cfg_i.mod0_src == SRC_HOST;
      sub_err_n_o <= !local_err;
    end
  end
endmodule

// File: rtl/subctl_port.sv
module subctl_port
  import subctl_pkg::*;
#(
  parameter int N_MOD     = 4,
  parameter int MIN_CYC   = 250000,
  parameter int QUIET_CYC = 250000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_wdata,
  input  logic             host_reset_i,
  input  logic             host_analyse_i,
  input  logic             up_reset_n_i,
  input  logic             up_analyse_n_i,
  input  logic             sub_reset_i,
  input  logic             sub_analyse_i,
  input  logic [N_MOD-1:0] mod_err_n_i,
  input  logic             sub_err_n_i,
  input  logic             down_err_n_i,
  output logic             mod0_reset_o,
  output logic             mod0_analyse_o,
  output logic             rest_reset_o,
  output logic             rest_analyse_o,
  output logic             down_reset_n_o,
  output logic             down_analyse_n_o,
  output logic             mod0_ready_o,
  output logic             rest_ready_o,
  output logic             up_err_n_o,
  output logic             host_err_o,
  output logic             mod0_sub_err_n_o
);
  localparam int N_GRP = 2;  // group 0: module 0, group 1: rest

  cfg_t cfg_q;
  logic cfg_src_up, cfg_follow_sub;

  subctl_cfg_reg u_cfg (
    .clk   (clk),
    .rst   (rst),
    .we    (cfg_we),
    .wdata (cfg_wdata),
    .cfg_o (cfg_q)
  );

  assign cfg_src_up     = (cfg_q.mod0_src == SRC_UP);
  assign cfg_follow_sub = (cfg_q.rest_src == FOLLOW_SUB);

  logic m0_rst_req, m0_ana_req;
  logic [N_GRP-1:0] rst_req, ana_req, rst_act, ana_act, rst_busy, ana_busy;

  assign m0_rst_req = cfg_src_up ? !up_reset_n_i   : host_reset_i;
  assign m0_ana_req = cfg_src_up ? !up_analyse_n_i : host_analyse_i;

  assign rst_req[0] = m0_rst_req;
  assign ana_req[0] = m0_ana_req;
  assign rst_req[1] = cfg_follow_sub ? sub_reset_i   : m0_rst_req;
  assign ana_req[1] = cfg_follow_sub ? sub_analyse_i : m0_ana_req;

  generate
    for (genvar g = 0; g < N_GRP; g++) begin : g_grp
      subctl_stretch #(.MIN_CYC(MIN_CYC), .QUIET_CYC(QUIET_CYC)) u_rst (
        .clk    (clk),
        .rst    (rst),
        .req_i  (rst_req[g]),
        .act_o  (rst_act[g]),
        .busy_o (rst_busy[g])
      );
      subctl_stretch #(.MIN_CYC(MIN_CYC), .QUIET_CYC(0)) u_ana (
        .clk    (clk),
        .rst    (rst),
        .req_i  (ana_req[g]),
        .act_o  (ana_act[g]),
        .busy_o (ana_busy[g])
      );
    end
  endgenerate

  assign mod0_reset_o     = rst_act[0];
  assign mod0_analyse_o   = ana_act[0];
  assign rest_reset_o     = rst_act[1];
  assign rest_analyse_o   = ana_act[1];
  assign down_reset_n_o   = !rst_act[1];
  assign down_analyse_n_o = !ana_act[1];
  assign mod0_ready_o     = !(rst_busy[0] || ana_busy[0]);
  assign rest_ready_o     = !(rst_busy[1] || ana_busy[1]);

  subctl_err_route #(.N_MOD(N_MOD)) u_err (
    .clk          (clk),
    .rst          (rst),
    .cfg_i        (cfg_q),
    .mod_err_n_i  (mod_err_n_i),
    .sub_err_n_i  (sub_err_n_i),
    .down_err_n_i (down_err_n_i),
    .up_err_n_o   (up_err_n_o),
    .host_err_o   (host_err_o),
    .sub_err_n_o  (mod0_sub_err_n_o)
  );
endmodule

// File: rtl/subctl_port_chk.sv
module subctl_port_chk #(
  parameter int N_MOD   = 4,
  parameter int MIN_CYC = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             cfg_src_up,
  input logic             cfg_follow_sub,
  input logic             host_reset_i,
  input logic             sub_reset_i,
  input logic [N_MOD-1:0] mod_err_n_i,
  input logic             down_err_n_i,
  input logic             mod0_reset_o,
  input logic             rest_reset_o,
  input logic             mod0_ready_o,
  input logic             up_err_n_o,
  input logic             host_err_o
);
  logic [31:0] run_q;
  always_ff @(posedge clk) begin
    if (rst) run_q <= '0;
    else if (mod0_reset_o) run_q <= (run_q == 32'hFFFF_FFFF) ? run_q : run_q + 1'b1;
    else run_q <= '0;
  end

  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (!mod0_reset_o && !rest_reset_o && up_err_n_o && !host_err_o));

  assert_host_select_R2: assert property (@(posedge clk) disable iff (rst)
    (!cfg_src_up && host_reset_i) |=> mod0_reset_o);

  assert_sub_follow_R3: assert property (@(posedge clk) disable iff (rst)
    (cfg_follow_sub && sub_reset_i) |=> rest_reset_o);

  assert_min_width_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(mod0_reset_o) |-> (run_q >= MIN_CYC));

  assert_not_ready_R7: assert property (@(posedge clk) disable iff (rst)
    mod0_reset_o |-> !mod0_ready_o);

  assert_master_err_R8: assert property (@(posedge clk) disable iff (rst)
    !mod_err_n_i[0] |=> (!up_err_n_o || host_err_o));

  assert_sub_local_R9: assert property (@(posedge clk) disable iff (rst)
    (&mod_err_n_i && down_err_n_i) |=> (up_err_n_o && !host_err_o));
endmodule

bind subctl_port subctl_port_chk #(.N_MOD(N_MOD), .MIN_CYC(MIN_CYC)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .cfg_src_up     (cfg_src_up),
  .cfg_follow_sub (cfg_follow_sub),
  .host_reset_i   (host_reset_i),
  .sub_reset_i    (sub_reset_i),
  .mod_err_n_i    (mod_err_n_i),
  .down_err_n_i   (down_err_n_i),
  .mod0_reset_o   (mod0_reset_o),
  .rest_reset_o   (rest_reset_o),
  .mod0_ready_o   (mod0_ready_o),
  .up_err_n_o     (up_err_n_o),
  .host_err_o     (host_err_o)
);

// File: tb/tb_subctl_port.sv
module tb_subctl_port;
  localparam int CLK_PERIOD = 10;
  localparam int N_MOD = 4;
  localparam int MINC  = 4;
  localparam int QUIET = 6;
  localparam int B_M0R = 0, B_M0A = 1, B_RR = 2, B_RA = 3, B_DRN = 4, B_DAN = 5;
  localparam int B_M0Y = 6, B_RY = 7, B_UPE = 8, B_HE = 9, B_SE = 10;

  logic clk = 1'b0, rst = 1'b1;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_wdata = 2'b00;
  logic host_reset_i = 0, host_analyse_i = 0, up_reset_n_i = 1, up_analyse_n_i = 1;
  logic sub_reset_i = 0, sub_analyse_i = 0;
  logic [N_MOD-1:0] mod_err_n_i = '1;
  logic sub_err_n_i = 1, down_err_n_i = 1;
  logic mod0_reset_o, mod0_analyse_o, rest_reset_o, rest_analyse_o;
  logic down_reset_n_o, down_analyse_n_o, mod0_ready_o, rest_ready_o;
  logic up_err_n_o, host_err_o, mod0_sub_err_n_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  subctl_port #(.N_MOD(N_MOD), .MIN_CYC(MINC), .QUIET_CYC(QUIET)) dut (.*);

  logic [10:0] obs;
  assign obs = {mod0_sub_err_n_o, host_err_o, up_err_n_o, rest_ready_o, mod0_ready_o,
                down_analyse_n_o, down_reset_n_o, rest_analyse_o, rest_reset_o,
                mod0_analyse_o, mod0_reset_o};

  typedef struct {
    int    cyc;
    int    idx;
    logic  val;
    string tag;
  } item_t;
  item_t sb[$];

  int cyc = 0, checks = 0, errors = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic expect_at(int at, int idx, logic val, string tag);
    item_t it;
    int i = 0;
    it.cyc = at; it.idx = idx; it.val = val; it.tag = tag;
    while (i < sb.size() && sb[i].cyc <= at) i++;
    sb.insert(i, it);
  endtask

  // monitor: pops due items and compares mid-cycle
  always @(negedge clk) begin
    if (!rst) begin
      while (sb.size() > 0 && sb[0].cyc <= cyc) begin
        item_t it;
        it = sb.pop_front();
        checks++;
        if (obs[it.idx] !== it.val) begin
          errors++;
          $display("FAIL %s cycle %0d bit %0d actual %b expected %b",
                   it.tag, cyc, it.idx, obs[it.idx], it.val);
        end
      end
    end
  end

  task automatic tick(int n = 1);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic wr_cfg(logic [1:0] v);
    cfg_we = 1'b1; cfg_wdata = v;
    tick();
    cfg_we = 1'b0;
    tick();
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      summary();
    end
  end

  initial begin
    int c;
    tick(3);
    rst = 1'b0;
    c = cyc;
    // R1: idle state right after reset
    for (int b = 0; b < 11; b++) expect_at(c + 1, b, (11'h5F0 >> b) & 1'b1, "R1 reset state");
    tick(3);

    // R5 R7 R4 R3: one-cycle host reset, host source, rest follows module 0
    c = cyc;
    host_reset_i = 1; up_analyse_n_i = 0;  // upstream analyse must be ignored (R2)
    tick();
    host_reset_i = 0;
    expect_at(c + 1, B_M0R, 1, "R5 pulse start");
    expect_at(c + 4, B_M0R, 1, "R5 pulse last cycle");
    expect_at(c + 5, B_M0R, 0, "R5 pulse end");
    expect_at(c + 1, B_RR, 1, "R3 rest follows mod0");
    expect_at(c + 5, B_RR, 0, "R3 rest follows mod0 end");
    expect_at(c + 1, B_DRN, 0, "R4 down reset low");
    expect_at(c + 5, B_DRN, 1, "R4 down reset released");
    expect_at(c + 1, B_M0Y, 0, "R7 ready low in pulse");
    expect_at(c + 10, B_M0Y, 0, "R7 ready low in quiet");
    expect_at(c + 11, B_M0Y, 1, "R7 ready after quiet");
    expect_at(c + 2, B_M0A, 0, "R2 upstream ignored in host mode");
    expect_at(c + 3, B_M0A, 0, "R2 upstream ignored in host mode");
    tick(12);
    up_analyse_n_i = 1;

    // R6: long analyse request, no quiet after analyse (R7)
    c = cyc;
    host_analyse_i = 1;
    tick(8);
    host_analyse_i = 0;
    expect_at(c + 8, B_M0A, 1, "R6 long request held");
    expect_at(c + 9, B_M0A, 0, "R6 falls after request");
    expect_at(c + 5, B_RA, 1, "R6 rest analyse held");
    expect_at(c + 3, B_DAN, 0, "R4 down analyse low");
    expect_at(c + 8, B_M0Y, 0, "R7 ready low in analyse");
    expect_at(c + 9, B_M0Y, 1, "R7 no quiet after analyse");
    tick(4);

    // R2: upstream source
    wr_cfg(2'b01);
    c = cyc;
    host_reset_i = 1;
    tick();
    host_reset_i = 0;
    expect_at(c + 1, B_M0R, 0, "R2 host ignored in upstream mode");
    expect_at(c + 2, B_M0R, 0, "R2 host ignored in upstream mode");
    tick(3);
    c = cyc;
    up_reset_n_i = 0;
    tick();
    up_reset_n_i = 1;
    expect_at(c + 1, B_M0R, 1, "R2 upstream reset start");
    expect_at(c + 5, B_M0R, 0, "R2 upstream reset end");
    expect_at(c + 11, B_M0Y, 1, "R7 ready after upstream reset");
    tick(13);

    // R3: rest group follows module 0's subsystem outputs
    wr_cfg(2'b11);
    c = cyc;
    sub_reset_i = 1;
    tick();
    sub_reset_i = 0;
    expect_at(c + 1, B_RR, 1, "R3 subsystem drives rest");
    expect_at(c + 4, B_RR, 1, "R5 rest pulse width");
    expect_at(c + 5, B_RR, 0, "R5 rest pulse end");
    expect_at(c + 1, B_M0R, 0, "R3 module 0 unaffected");
    expect_at(c + 2, B_DRN, 0, "R4 down follows rest");
    expect_at(c + 2, B_M0Y, 1, "R7 module 0 still ready");
    expect_at(c + 10, B_RY, 0, "R7 rest quiet");
    expect_at(c + 11, B_RY, 1, "R7 rest ready");
    tick(12);
    c = cyc;
    up_analyse_n_i = 0;
    tick();
    up_analyse_n_i = 1;
    expect_at(c + 1, B_M0A, 1, "R2 upstream analyse");
    expect_at(c + 1, B_RA, 0, "R3 rest ignores module 0 source");
    tick(6);

    // R10: rest errors go local when following subsystem
    c = cyc;
    mod_err_n_i[3] = 0;
    tick();
    mod_err_n_i[3] = 1;
    expect_at(c + 1, B_SE, 0, "R10 rest error local");
    expect_at(c + 1, B_UPE, 1, "R10 rest error not upstream");
    expect_at(c + 2, B_SE, 1, "R10 rest error cleared");
    tick(2);
    c = cyc;
    down_err_n_i = 0;
    tick();
    down_err_n_i = 1;
    expect_at(c + 1, B_SE, 0, "R10 down error local");
    expect_at(c + 1, B_UPE, 1, "R10 down error not upstream");
    tick(2);

    // R8 R10: follows module 0, upstream source
    wr_cfg(2'b01);
    c = cyc;
    mod_err_n_i[2] = 0;
    tick();
    mod_err_n_i[2] = 1;
    expect_at(c + 1, B_UPE, 0, "R8 rest error upstream");
    expect_at(c + 1, B_HE, 0, "R8 no host error");
    expect_at(c + 1, B_SE, 1, "R10 rest error not local");
    tick(2);
    c = cyc;
    sub_err_n_i = 0;
    tick();
    sub_err_n_i = 1;
    expect_at(c + 1, B_SE, 0, "R9 subsystem error local");
    expect_at(c + 1, B_UPE, 1, "R9 subsystem error not upstream");
    tick(2);

    // R8 R9: host source
    wr_cfg(2'b00);
    c = cyc;
    mod_err_n_i[0] = 0;
    tick();
    mod_err_n_i[0] = 1;
    expect_at(c + 1, B_HE, 1, "R8 module 0 error to host");
    expect_at(c + 1, B_UPE, 1, "R8 upstream idle in host mode");
    tick(2);
    c = cyc;
    sub_err_n_i = 0;
    tick();
    sub_err_n_i = 1;
    expect_at(c + 1, B_HE, 0, "R9 subsystem error not to host");
    expect_at(c + 1, B_SE, 0, "R9 subsystem error local");
    tick(4);

    if (sb.size() != 0) begin
      checks++; errors++;
      $display("FAIL scoreboard: actual %0d items left expected 0", sb.size());
    end
    done = 1;
    summary();
  end
endmodule